// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel data buses, A and B, in either direction. Each direction owns a capture register loaded by its own strobe. The block can pass live data from the opposite bus straight through, or it can send the value held in that direction's register. A single active-low output enable and a direction select decide which bus, if either, is driven. Two source selects choose live or held data for each direction.

Each bus is modelled as separate input, output and output-enable vectors so the block can be synthesised and tested without tri-state nets. A pad ring or wrapper turns each out/oe pair into a real tri-state driver. The two capture strobes are single-cycle enables on one system clock. A strobe that is high at a rising clock edge loads its register. A build-time parameter selects a non-inverting or an inverting data path.

The block moves plain parallel words with no handshake, so it has no valid/ready interface and no back-pressure. The data outputs always carry the selected word. The output-enable pins alone decide whether that word reaches a bus.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both capture registers are zero. With `oe_n`=0, `dir_to_b`=1 and `hold_sel_ab`=1, `b_out` then reads 0 on the non-inverting variant.
- R2: When `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R3: When `oe_n` is 0, `dir_to_b`=0 sets `a_oe`=1 and `b_oe`=0, and `dir_to_b`=1 sets `b_oe`=1 and `a_oe`=0. The two enables are never 1 together.
- R4: If `cap_ab` is 1 at a rising clock edge, the A-to-B register takes `a_in`. If `cap_ab` is 0, that register keeps its value.
- R5: If `cap_ba` is 1 at a rising clock edge, the B-to-A register takes `b_in`. If `cap_ba` is 0, that register keeps its value.
- R6: Register loading does not depend on `oe_n`, `dir_to_b`, `hold_sel_ab` or `hold_sel_ba`. Both registers can load while the outputs are isolated.
- R7: `b_out` equals `a_in` when `hold_sel_ab`=0 and the A-to-B register when `hold_sel_ab`=1. The live path is combinational, so a change on `a_in` shows on `b_out` in the same cycle.
- R8: `a_out` equals `b_in` when `hold_sel_ba`=0 and the B-to-A register when `hold_sel_ba`=1. This path is also combinational.
- R9: With `INVERT`=1, `a_out` and `b_out` carry the bitwise complement of the data selected by R7 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; registers load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir_to_b | input | 1 | 1: bus B is driven from the A side; 0: bus A is driven from the B side |
| cap_ab | input | 1 | Load strobe for the A-to-B register |
| cap_ba | input | 1 | Load strobe for the B-to-A register |
| hold_sel_ab | input | 1 | 1: B side sends held A data; 0: live A data |
| hold_sel_ba | input | 1 | 1: A side sends held B data; 0: live B data |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Word offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Word offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The assertions check, on every cycle, that the enables obey the isolation and direction rules. They also check that each register loads its input on its strobe and otherwise stays unchanged, and that the live paths forward the input word, after inversion if chosen, on both outputs. Some behaviour shows only when several cycles are chained together, so the bench scenarios cover it. These cases are the reset value seen through the held path, loading both registers while the outputs are isolated and then reading them back, and the inverted variant compared against a reference model under random control mixes.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/regbus_capture.sv
module regbus_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R4 / R5: load takes the input, no load keeps the register
  a_r4_load_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
  a_r5_idle_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/regbus_path_mux.sv
module regbus_path_mux
  import regbus_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] out
);
  logic [W-1:0] pick;

  always_comb pick = (sel == SRC_HELD) ? held : live;

  generate
    if (INVERT) begin : g_inv
      assign out = ~pick;
    end else begin : g_pass
      assign out = pick;
    end
  endgenerate
endmodule

// File: rtl/regbus_drive_ctrl.sv
module regbus_drive_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic dir_to_b,
  output logic a_oe,
  output logic b_oe
);
  always_comb begin
    a_oe = 1'b0;
    b_oe = 1'b0;
    if (!oe_n) begin
      if (dir_to_b) b_oe = 1'b1;
      else          a_oe = 1'b1;
    end
  end

  a_r2_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));
  a_r3_one_bus_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> $countones({a_oe, b_oe}) == 1 && (b_oe == dir_to_b));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir_to_b,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         hold_sel_ab,
  input  logic         hold_sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : '0;

  logic [W-1:0] held_ab, held_ba;

  // R4, R5, R6: loads depend only on their strobes
  regbus_capture #(.W(W)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .load(cap_ab), .d(a_in), .q(held_ab));
  regbus_capture #(.W(W)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .load(cap_ba), .d(b_in), .q(held_ba));

  regbus_path_mux #(.W(W), .INVERT(INVERT)) u_mux_to_b (
    .sel(src_sel_e'(hold_sel_ab)), .live(a_in), .held(held_ab), .out(b_out));
  regbus_path_mux #(.W(W), .INVERT(INVERT)) u_mux_to_a (
    .sel(src_sel_e'(hold_sel_ba)), .live(b_in), .held(held_ba), .out(a_out));

  regbus_drive_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_to_b(dir_to_b),
    .a_oe(a_oe), .b_oe(b_oe));

  // R7 / R8 / R9: live paths forward the opposite bus (complemented if inverting)
  a_r7_live_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_sel_ab |-> b_out == (a_in ^ FLIP));
  a_r8_live_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_sel_ba |-> a_out == (b_in ^ FLIP));
  // R6: a strobe during isolation still loads, seen later via the held path
  a_r6_load_while_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && cap_ab) |=> held_ab == $past(a_in));
endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_n = 1'b1, dir_to_b = 1'b0, cap_ab = 1'b0, cap_ba = 1'b0;
  logic hold_sel_ab = 1'b0, hold_sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, a_out_i, b_out_i;
  logic a_oe, b_oe, a_oe_i, b_oe_i;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regbus_xcvr #(.W(W), .INVERT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_to_b(dir_to_b),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .hold_sel_ab(hold_sel_ab),
    .hold_sel_ba(hold_sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  regbus_xcvr #(.W(W), .INVERT(1'b1)) u_dut_inv (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_to_b(dir_to_b),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .hold_sel_ab(hold_sel_ab),
    .hold_sel_ba(hold_sel_ba), .a_in(a_in), .a_out(a_out_i), .a_oe(a_oe_i),
    .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i));

  // Behavioural reference: two stored words
  int m_ab = 0, m_ba = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab = 0; m_ba = 0;
    end else begin
      if (cap_ab) m_ab = a_in;
      if (cap_ba) m_ba = b_in;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int eb, ea;
    eb = hold_sel_ab ? m_ab : int'(a_in);
    ea = hold_sel_ba ? m_ba : int'(b_in);
    check("R7 b_out", b_out, eb);
    check("R8 a_out", a_out, ea);
    check("R9 b_out inverted", b_out_i, eb ^ 8'hFF);
    check("R9 a_out inverted", a_out_i, ea ^ 8'hFF);
    check("R2/R3 a_oe", a_oe, int'(!oe_n && !dir_to_b));
    check("R2/R3 b_oe", b_oe, int'(!oe_n && dir_to_b));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset value visible through the held paths
    oe_n = 0; dir_to_b = 1; hold_sel_ab = 1; hold_sel_ba = 1;
    a_in = 8'hA5; b_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    check("R1 b_out reset", b_out, 0);
    check("R1 a_out reset", a_out, 0);
    check("R1 R9 inverted reset", b_out_i, 8'hFF);
    rst_n = 1;
    @(negedge clk);

    // R2: isolation
    oe_n = 1; #1;
    check("R2 a_oe", a_oe, 0);
    check("R2 b_oe", b_oe, 0);
    // R3: direction
    oe_n = 0; dir_to_b = 0; #1;
    check("R3 a_oe dir0", a_oe, 1);
    check("R3 b_oe dir0", b_oe, 0);
    dir_to_b = 1; #1;
    check("R3 b_oe dir1", b_oe, 1);
    check("R3 a_oe dir1", a_oe, 0);

    // R4, R5, R6: load both while isolated, with other controls toggled
    @(negedge clk);
    oe_n = 1; hold_sel_ab = 0; hold_sel_ba = 0; dir_to_b = 0;
    a_in = 8'h5A; b_in = 8'hC3; cap_ab = 1; cap_ba = 1;
    step();
    cap_ab = 0; cap_ba = 0; a_in = 8'h00; b_in = 8'hFF;
    step();
    oe_n = 0; dir_to_b = 1; hold_sel_ab = 1; hold_sel_ba = 1; #1;
    check("R4 R6 held A word", b_out, 8'h5A);
    check("R5 R6 held B word", a_out, 8'hC3);
    check("R9 held A inverted", b_out_i, 8'hA5);

    // R7, R8: live path within the same cycle
    hold_sel_ab = 0; hold_sel_ba = 0; a_in = 8'h11; b_in = 8'h22; #1;
    check("R7 live same cycle", b_out, 8'h11);
    check("R8 live same cycle", a_out, 8'h22);
    a_in = 8'h99; #1;
    check("R7 live follows", b_out, 8'h99);

    // Random phase against the reference model, every cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      {oe_n, dir_to_b, cap_ab, cap_ba, hold_sel_ab, hold_sel_ba} = 6'($urandom);
      a_in = 8'($urandom); b_in = 8'($urandom);
      #1 compare_all();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule